// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial line back into characters. It runs on the system clock and advances only on a one-cycle tick that arrives sixteen times per bit period. The line is first passed through a flop synchronizer. The receiver then does the following for each character:

- finds a falling edge and confirms the start bit at its midpoint;
- samples every later bit at its centre, least significant bit first;
- after the last data bit, takes an optional parity bit;
- judges the frame on the first stop bit only.

Five control inputs shape the frame: a two-bit length code, a nine-bit extension, parity enable, even select and stick parity. They are read when the start bit is confirmed. Each finished character appears with a one-cycle valid strobe, together with parity-error, framing-error and break flags. The data and flags hold their values until the next character.

The state machine has six states:

| State | Transition |
|---|---|
| `ST_IDLE` | A tick that sees the line low goes to `ST_START` (start edge seen). |
| `ST_START` | The eighth tick goes to `ST_DATA` if the line is low (start confirmed), or back to `ST_IDLE` if it is high (glitch rejected). |
| `ST_DATA` | After the last data bit, goes to `ST_PAR` when parity is enabled, or to `ST_STOP` when it is not. |
| `ST_PAR` | After the parity sample, goes to `ST_STOP`. |
| `ST_STOP` | Samples the first stop bit and delivers the character. A high stop bit returns to `ST_IDLE`. A low stop bit goes to `ST_HOLD`. |
| `ST_HOLD` | Goes to `ST_IDLE` once the line reads high. |

Top module: `uart_rx_frame`

## Requirements
- R1: The length code `len_sel` picks the number of data bits: 00→5, 01→6, 10→7, 11→8. The received value sits in `rx_data` from bit 0 up, and the unused upper bits read zero.
- R2: With `len9_en`=1 and `len_sel`=00, nine data bits are received. With any other `len_sel` value, `len9_en` has no effect.
- R3: With parity enabled and stick parity off, the data bits and the parity bit together must hold an even number of ones when `par_even`=1, and an odd number when `par_even`=0. Otherwise `err_parity`=1.
- R4: With stick parity on, the parity bit must be 1 when `par_even`=0 and 0 when `par_even`=1. Any other value sets `err_parity`.
- R5: With `par_en`=0, no parity bit is expected. The bit after the last data bit is the stop bit, and `err_parity` stays 0.
- R6: A falling edge starts a character only if the line is still low at the eighth tick after it. A shorter low pulse produces no character.
- R7: Later bits are sampled every 16 ticks at mid-bit, least significant bit first. `rx_valid` is high for exactly one clock per character.
- R8: Only the first stop bit is examined. The character is delivered while that first stop bit is still on the line, whatever number of stop bits the sender uses.
- R9: A low first stop bit sets `err_frame` for that character.
- R10: `brk_det` is set when all data bits are zero, the parity bit (if enabled) is zero and the first stop bit is low. A character with any 1 among these bits gives `brk_det`=0.
- R11: After a framing error, no new start is looked for until the line has been high. A line held low for many bit times yields exactly one character.
- R12: After reset, `rx_valid`, `rx_data`, `err_parity`, `err_frame` and `brk_det` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe, 16 per bit period |
| rxd_in | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Data length code (5 to 8 bits) |
| len9_en | input | 1 | Selects nine data bits together with `len_sel`=00 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even (1) or odd (0) parity |
| par_stick | input | 1 | Parity bit fixed by `par_even` |
| rx_data | output | 9 | Last received character |
| rx_valid | output | 1 | One-cycle strobe: new character |
| err_parity | output | 1 | Parity mismatch on last character |
| err_frame | output | 1 | First stop bit was low |
| brk_det | output | 1 | Break condition on last character |

## Verification
The start bit is confirmed 8 ticks after the synchronized edge. Each later bit is taken 16 ticks after the previous sample. The character, with its flags, therefore appears one clock after the tick that samples the middle of the first stop bit, roughly 9 ticks into that bit. The bench captures the strobe and the outputs at the falling clock edge, together with a marker showing whether the first stop bit was still being driven. All comparisons are made after the frame has been fully sent, against that captured snapshot. No check depends on an exact edge: tests that expect no character, or only one, wait several bit periods before counting strobes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int NB_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [NB_W-1:0] nbits;
        logic            par_en;
        logic            par_even;
        logic            par_stick;
    } rx_cfg_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_cfg_decode.sv
module rx_cfg_decode
    import uart_rx_pkg::*;
#(
    parameter int MIN_BITS = 5
) (
    input  logic [1:0] len_sel,
    input  logic       len9_en,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output rx_cfg_t    cfg
);
    localparam logic [NB_W-1:0] BASE = NB_W'(MIN_BITS);
    localparam logic [NB_W-1:0] LONG = NB_W'(MIN_BITS + 4);

    always_comb begin
        if (len9_en && (len_sel == 2'b00)) cfg.nbits = LONG;
        else                               cfg.nbits = BASE + NB_W'(len_sel);
        cfg.par_en    = par_en;
        cfg.par_even  = par_even;
        cfg.par_stick = par_stick;
    end
endmodule

// File: rtl/rx_check.sv
module rx_check
    import uart_rx_pkg::*;
#(
    parameter int MAX_DATA = 9
) (
    input  logic [MAX_DATA-1:0] data,
    input  rx_cfg_t             cfg,
    input  logic                pbit,
    input  logic                stop_bit,
    output logic                par_err,
    output logic                frm_err,
    output logic                brk
);
    logic ones_odd;

    always_comb begin
        ones_odd = (^data) ^ pbit;
        if (!cfg.par_en)        par_err = 1'b0;
        else if (cfg.par_stick) par_err = (pbit == cfg.par_even);
        else if (cfg.par_even)  par_err = ones_odd;
        else                    par_err = !ones_odd;
        frm_err = !stop_bit;
        brk     = !stop_bit && (data == '0) && !pbit;
    end
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int MAX_DATA   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx_s,
    input  rx_cfg_t             cfg_in,
    output logic [MAX_DATA-1:0] rx_data,
    output logic                rx_valid,
    output logic                err_parity,
    output logic                err_frame,
    output logic                brk_det
);
    localparam int CW   = $clog2(OVERSAMPLE);
    localparam int HALF = OVERSAMPLE / 2;
    localparam logic [CW-1:0] CNT_HALF = CW'(HALF - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(OVERSAMPLE - 1);

    rx_state_e         state, state_nx;
    logic [CW-1:0]     cnt_q;
    logic [NB_W-1:0]   idx_q;
    logic [MAX_DATA-1:0] data_q;
    logic              pbit_q;
    rx_cfg_t           cfg_q;
    logic              half_hit, full_hit, last_bit;
    logic              chk_par, chk_frm, chk_brk;

    assign half_hit = tick && (cnt_q == CNT_HALF);
    assign full_hit = tick && (cnt_q == CNT_FULL);
    assign last_bit = (idx_q == cfg_q.nbits - NB_W'(1));

    rx_check #(.MAX_DATA(MAX_DATA)) chk_i (
        .data     (data_q),
        .cfg      (cfg_q),
        .pbit     (pbit_q),
        .stop_bit (rx_s),
        .par_err  (chk_par),
        .frm_err  (chk_frm),
        .brk      (chk_brk)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick && !rx_s) state_nx = ST_START;
            ST_START: if (half_hit) state_nx = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:  if (full_hit && last_bit)
                          state_nx = cfg_q.par_en ? ST_PAR : ST_STOP;
            ST_PAR:   if (full_hit) state_nx = ST_STOP;
            ST_STOP:  if (full_hit) state_nx = rx_s ? ST_IDLE : ST_HOLD;
            ST_HOLD:  if (rx_s) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // tick counter, bit index, parity bit, configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            pbit_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            if (state_nx != state) cnt_q <= '0;
            else if (tick)         cnt_q <= (cnt_q == CNT_FULL) ? '0 : cnt_q + CW'(1);

            if (state == ST_IDLE) pbit_q <= 1'b0;
            else if (state == ST_PAR && full_hit) pbit_q <= rx_s;

            if (state == ST_START && state_nx == ST_DATA) begin
                cfg_q <= cfg_in;
                idx_q <= '0;
            end else if (state == ST_DATA && full_hit) begin
                idx_q <= idx_q + NB_W'(1);
            end
        end
    end

    // data assembly, least significant bit first
    for (genvar g = 0; g < MAX_DATA; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_q[g] <= 1'b0;
            else if (state == ST_IDLE)
                data_q[g] <= 1'b0;
            else if (state == ST_DATA && full_hit && idx_q == NB_W'(g))
                data_q[g] <= rx_s;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            brk_det    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (state == ST_STOP && full_hit) begin
                rx_valid   <= 1'b1;
                rx_data    <= data_q;
                err_parity <= chk_par;
                err_frame  <= chk_frm;
                brk_det    <= chk_brk;
            end
        end
    end

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r7_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(tick));

    a_r10_break_framed: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det |-> err_frame);

    a_r5_no_parity_error: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_q.par_en) |-> !err_parity);

    a_r11_hold_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> err_frame);

    a_r1_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (idx_q < cfg_q.nbits));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DATA    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                rxd_in,
    input  logic [1:0]          len_sel,
    input  logic                len9_en,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                par_stick,
    output logic [MAX_DATA-1:0] rx_data,
    output logic                rx_valid,
    output logic                err_parity,
    output logic                err_frame,
    output logic                brk_det
);
    logic    rx_s;
    rx_cfg_t cfg;

    rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd_in),
        .dout  (rx_s)
    );

    rx_cfg_decode #(.MIN_BITS(MAX_DATA - 4)) dec_i (
        .len_sel   (len_sel),
        .len9_en   (len9_en),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .cfg       (cfg)
    );

    rx_fsm #(.OVERSAMPLE(OVERSAMPLE), .MAX_DATA(MAX_DATA)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .rx_s       (rx_s),
        .cfg_in     (cfg),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .err_parity (err_parity),
        .err_frame  (err_frame),
        .brk_det    (brk_det)
    );
endmodule

// File: tb/uart_rx_frame_tb_top.sv
module uart_rx_frame_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd_in = 1'b1;
    logic [1:0] len_sel = 2'b11;
    logic       len9_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, err_parity, err_frame, brk_det;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int tdiv = 0;

    logic       in_stop1 = 1'b0;
    int         got_cnt = 0;
    logic [8:0] got_data = '0;
    logic       got_pe = 1'b0, got_fe = 1'b0, got_brk = 1'b0, got_in_stop1 = 1'b0;

    uart_rx_frame dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_in(rxd_in),
        .len_sel(len_sel), .len9_en(len9_en), .par_en(par_en),
        .par_even(par_even), .par_stick(par_stick),
        .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
        .err_frame(err_frame), .brk_det(brk_det)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICK_DIV-2);
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt      = got_cnt + 1;
            got_data     = rx_data;
            got_pe       = err_parity;
            got_fe       = err_frame;
            got_brk      = brk_det;
            got_in_stop1 = in_stop1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_nbits(input logic [1:0] ls, input logic l9);
        if (l9 && ls == 2'b00) return 9;
        return 5 + int'(ls);
    endfunction

    function automatic logic [8:0] mask_data(input logic [8:0] d, input int n);
        return d & 9'((1 << n) - 1);
    endfunction

    function automatic logic good_pbit(input logic [8:0] d, input logic ev, input logic st);
        if (st) return !ev;
        return ev ? (^d) : !(^d);
    endfunction

    task automatic wait_tick();
        do @(negedge clk); while (!tick16);
        @(posedge clk);
        #1;
    endtask

    task automatic drive_bit(input logic v);
        rxd_in = v;
        repeat (16) wait_tick();
    endtask

    task automatic send_frame(input logic [8:0] d, input int n, input logic pe,
                              input logic pb, input logic stop1, input int nstop);
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(d[i]);
        if (pe) drive_bit(pb);
        in_stop1 = 1'b1;
        drive_bit(stop1);
        in_stop1 = 1'b0;
        for (int i = 1; i < nstop; i++) drive_bit(1'b1);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic run_frame(input string req, input logic [1:0] ls, input logic l9,
                             input logic pe, input logic ev, input logic st,
                             input logic [8:0] raw, input logic bad_par,
                             input logic stop1, input int nstop);
        int n;
        logic [8:0] d;
        logic pb, exp_brk;
        n = exp_nbits(ls, l9);
        d = mask_data(raw, n);
        pb = pe ? (good_pbit(d, ev, st) ^ bad_par) : 1'b0;
        exp_brk = !stop1 && (d == 0) && !pb;
        len_sel = ls; len9_en = l9; par_en = pe; par_even = ev; par_stick = st;
        got_cnt = 0;
        send_frame(d, n, pe, pb, stop1, nstop);
        chk({req, " count"}, got_cnt, 1);
        chk({req, " data"}, int'(got_data), int'(d));
        chk({req, " parity flag"}, int'(got_pe), int'(pe && bad_par));
        chk({req, " frame flag"}, int'(got_fe), int'(!stop1));
        chk({req, " break flag"}, int'(got_brk), int'(exp_brk));
        chk("R8 delivered in first stop bit", int'(got_in_stop1), 1);
    endtask

    initial begin
        void'($urandom(32'd20250811));
        repeat (5) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 valid", int'(rx_valid), 0);
        chk("R12 data", int'(rx_data), 0);
        chk("R12 flags", int'({err_parity, err_frame, brk_det}), 0);
        rst_n = 1'b1;
        repeat (3) drive_bit(1'b1);

        // R1 / R7: each length, no parity
        run_frame("R1 len5", 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1F5, 1'b0, 1'b1, 1);
        run_frame("R1 len6", 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 9'h02D, 1'b0, 1'b1, 1);
        run_frame("R1 len7", 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 9'h153, 1'b0, 1'b1, 1);
        run_frame("R7 lsb first", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 9'h001, 1'b0, 1'b1, 1);
        // R2: nine bits, and extension ignored with other codes
        run_frame("R2 len9", 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 9'h1A5, 1'b0, 1'b1, 1);
        run_frame("R2 ext ignored", 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b1, 1);
        // R3: normal parity
        run_frame("R3 even ok", 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0B7, 1'b0, 1'b1, 1);
        run_frame("R3 even bad", 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0B7, 1'b1, 1'b1, 1);
        run_frame("R3 odd bad", 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 9'h10F, 1'b1, 1'b1, 1);
        // R4: stick parity
        run_frame("R4 stick one ok", 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 9'h011, 1'b0, 1'b1, 1);
        run_frame("R4 stick one bad", 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 9'h011, 1'b1, 1'b1, 1);
        run_frame("R4 stick zero bad", 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 9'h0F0, 1'b1, 1'b1, 1);
        // R5: no parity bit; data ending in 0 then stop
        run_frame("R5 no parity", 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 9'h01E, 1'b0, 1'b1, 1);
        // R8: two stop bits sent
        run_frame("R8 two stops", 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b1, 2);
        // R9: framing error, non-break
        run_frame("R9 framing", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055, 1'b0, 1'b0, 1);
        // R10: zeros with a set parity bit is not a break
        run_frame("R10 no break", 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0, 1);

        // R6: short low pulse ignored
        got_cnt = 0;
        rxd_in = 1'b0;
        repeat (3) wait_tick();
        rxd_in = 1'b1;
        repeat (4) drive_bit(1'b1);
        chk("R6 glitch ignored", got_cnt, 0);
        run_frame("R6 after glitch", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0C9, 1'b0, 1'b1, 1);

        // R10 / R11: long break, 8 bits, even parity
        len_sel = 2'b11; len9_en = 1'b0; par_en = 1'b1; par_even = 1'b1; par_stick = 1'b0;
        got_cnt = 0;
        repeat (30) drive_bit(1'b0);
        repeat (3) drive_bit(1'b1);
        chk("R11 one char on held low", got_cnt, 1);
        chk("R10 break data", int'(got_data), 0);
        chk("R10 break flag", int'(got_brk), 1);
        chk("R9 break framing", int'(got_fe), 1);
        chk("R10 break parity", int'(got_pe), 0);
        run_frame("R11 recovers", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A3, 1'b0, 1'b1, 1);

        // random mix
        for (int k = 0; k < 24; k++) begin
            logic [1:0] ls;
            logic l9, pe, ev, st, bp;
            logic [8:0] dd;
            int ns;
            ls = 2'($urandom);
            l9 = 1'($urandom);
            pe = 1'($urandom);
            ev = 1'($urandom);
            st = ($urandom % 4) == 0;
            bp = pe && (($urandom % 4) == 0);
            dd = 9'($urandom);
            ns = 1 + int'($urandom % 2);
            run_frame("R7 random", ls, l9, pe, ev, st, dd, bp, 1'b1, ns);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule